// File: doc/BRIEF.md
# Longest Carry-Chain Length Meter

This unit watches the operand pairs fed to an N-bit adder and reports how far the longest carry travels in that operation. Each bit position is sorted into one of three kinds: it creates a carry, it passes an incoming carry on, or it absorbs one. The unit then finds the longest run that starts at a carry-creating bit and continues through carry-passing bits. When the subtract select is high, the second operand is inverted and the injected carry-in acts as a carry source sitting just below bit 0.

Alongside the length, the unit raises a flag when a segmented speculative adder would have given the right answer. Such an adder lets a carry travel at most a given window of bits. The window is an input sampled together with the operands. Results are registered and appear one cycle after the valid strobe. The unit is meant to sit beside a datapath and profile its operand stream. Any counting or binning of the results happens outside it.

Top module: `carry_run_meter`

## Requirements
- R1: Bit i is classed as generate when opA[i] and the effective second operand bit are both 1, as propagate when exactly one of them is 1, and as annihilate when both are 0. The effective second operand is opB for an addition (subIn=0) and ~opB for a subtraction (subIn=1).
- R2: A chain of length L is one generate at bit i followed by L-1 propagates at bits i+1 to i+L-1. lenOut reports the largest such L over the word.
- R3: A chain ends at an annihilate, or at a generate (which starts a new chain of length 1), or at bit WIDTH-1.
- R4: In an addition with no generate bit, lenOut is 0.
- R5: In a subtraction the carry-in is a source of length 0 below bit 0, so a run of propagates starting at bit 0 counts toward the length. Subtracting 0 from 0 gives lenOut = WIDTH.
- R6: okOut is 1 exactly when the reported length is strictly less than the window value sampled with the same strobe.
- R7: When validIn is high at a clock edge, lenOut and okOut show that operation's result after that edge, and validOut is high for exactly that one cycle. validOut is 0 after any edge where validIn was 0.
- R8: While validIn is low, lenOut and okOut keep their last values.
- R9: During and right after reset, validOut, lenOut and okOut are 0.
- R10: lenOut never exceeds WIDTH. It is ceil(log2(WIDTH+1)) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands, subtract select and window are valid this cycle |
| subIn | input | 1 | 1 = subtraction (invert opB, carry-in 1), 0 = addition |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand (subtrahend when subIn=1) |
| window | input | LEN_W | Largest carry travel of the speculative adder plus one |
| validOut | output | 1 | Registered result is new this cycle |
| lenOut | output | LEN_W | Longest carry-chain length |
| okOut | output | 1 | Speculation would have succeeded (lenOut < window) |

## Verification
The assertions are evaluated on every cycle. They cover the one-cycle valid latency, the hold of the result while idle, the upper bound on the length, the relation between okOut and the window, and two anchor cases: an addition with no generate bit gives zero, and 0 minus 0 gives the full width. Only the bench's scenarios show that the length itself is correct for general operands. That includes termination by an annihilate, restart at a new generate, a chain running to the top bit, and the long chains produced by small subtrahends. The bench compares each of these against its reference loop on every clock.

// File: rtl/crm_pkg.sv
package crm_pkg;

  // Carry behaviour of a single bit position
  typedef enum logic [1:0] {
    BIT_KILL = 2'd0,
    BIT_PROP = 2'd1,
    BIT_GEN  = 2'd2
  } bitKind_e;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;   // load result registers this cycle
    logic subtract;  // treat operands as a subtraction
  } crmStrobe_t;

endpackage

// File: rtl/crm_ctrl.sv
module crm_ctrl
  import crm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       subIn,
  output crmStrobe_t strobe,
  output logic       validOut
);

  always_comb begin
    strobe.capture  = validIn;
    strobe.subtract = subIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/crm_datapath.sv
module crm_datapath
  import crm_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [LEN_W-1:0] window,
  input  crmStrobe_t       strobe,
  output logic [LEN_W-1:0] lenOut,
  output logic             okOut
);

  logic [WIDTH-1:0]            opBEff;
  bitKind_e [WIDTH-1:0]        kind;
  // slot 0 is the carry-in source below bit 0
  logic [WIDTH:0]              live;
  logic [WIDTH:0][LEN_W-1:0]   runLen;
  logic [LEN_W-1:0]            best;

  assign opBEff    = strobe.subtract ? ~opB : opB;
  assign live[0]   = strobe.subtract;
  assign runLen[0] = '0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign kind[i] = (opA[i] & opBEff[i]) ? BIT_GEN :
                     (opA[i] ^ opBEff[i]) ? BIT_PROP : BIT_KILL;

    assign live[i+1] = (kind[i] == BIT_GEN) |
                       ((kind[i] == BIT_PROP) & live[i]);

    assign runLen[i+1] = (kind[i] == BIT_GEN)              ? LEN_W'(1) :
                         ((kind[i] == BIT_PROP) && live[i]) ? runLen[i] + LEN_W'(1) :
                                                              '0;
  end

  always_comb begin
    best = '0;
    for (int j = 1; j <= WIDTH; j++) begin
      if (runLen[j] > best) best = runLen[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenOut <= '0;
      okOut  <= 1'b0;
    end else if (strobe.capture) begin
      lenOut <= best;
      okOut  <= (best < window);
    end
  end

endmodule

// File: rtl/carry_run_meter.sv
module carry_run_meter
  import crm_pkg::*;
#(
  parameter  int WIDTH = 32,
  localparam int LEN_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic             subIn,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [LEN_W-1:0] window,
  output logic             validOut,
  output logic [LEN_W-1:0] lenOut,
  output logic             okOut
);

  crmStrobe_t strobe;

  crm_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .subIn    (subIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  crm_datapath #(.WIDTH(WIDTH), .LEN_W(LEN_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .window (window),
    .strobe (strobe),
    .lenOut (lenOut),
    .okOut  (okOut)
  );

endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
  parameter int WIDTH = 32,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic             subIn,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [LEN_W-1:0] window,
  input logic             validOut,
  input logic [LEN_W-1:0] lenOut,
  input logic             okOut
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);  // R7

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);  // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(lenOut) && $stable(okOut)));  // R8

  AST_OK_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> (okOut == (lenOut < $past(window))));  // R6

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lenOut <= LEN_W'(WIDTH));  // R10

  AST_NO_GEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !subIn && ((opA & opB) == '0)) |=> (lenOut == '0));  // R4

  AST_SUB_ZERO_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && subIn && (opA == '0) && (opB == '0)) |=> (lenOut == LEN_W'(WIDTH)));  // R5

endmodule

bind carry_run_meter crm_checker #(.WIDTH(WIDTH), .LEN_W(LEN_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .subIn    (subIn),
  .opA      (opA),
  .opB      (opB),
  .window   (window),
  .validOut (validOut),
  .lenOut   (lenOut),
  .okOut    (okOut)
);

// File: tb/carry_run_meter_tb_top.sv
`timescale 1ns/1ps
module carry_run_meter_tb_top;

  localparam int WIDTH = 32;
  localparam int LEN_W = $clog2(WIDTH + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             validIn = 1'b0;
  logic             subIn = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic [LEN_W-1:0] window = '0;
  logic             validOut;
  logic [LEN_W-1:0] lenOut;
  logic             okOut;

  int  nVec = 0;
  int  nBad = 0;
  bit  done = 0;

  // expected state of the outputs after the next edge
  bit  expValid = 0;
  int  expLen   = 0;
  bit  expOk    = 0;
  string expTag = "R9";

  always #4 clk = ~clk;

  carry_run_meter #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .subIn(subIn),
    .opA(opA), .opB(opB), .window(window),
    .validOut(validOut), .lenOut(lenOut), .okOut(okOut)
  );

  // behavioural reference: walk the bits from the bottom
  function automatic int refLen(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, bit sub);
    logic [WIDTH-1:0] bb;
    int run;
    int best;
    bit carrying;
    bb = sub ? ~b : b;
    run = 0;
    best = 0;
    carrying = sub;
    for (int i = 0; i < WIDTH; i++) begin
      if (a[i] && bb[i]) begin
        run = 1; carrying = 1;
      end else if ((a[i] != bb[i]) && carrying) begin
        run = run + 1;
      end else begin
        run = 0; carrying = 0;
      end
      if (run > best) best = run;
    end
    return best;
  endfunction

  task automatic compareNow();
    nVec++;
    if (validOut !== expValid || lenOut !== LEN_W'(expLen) || okOut !== expOk) begin
      nBad++;
      $display("FAIL %s: got valid=%0b len=%0d ok=%0b, expected valid=%0b len=%0d ok=%0b",
               expTag, validOut, lenOut, okOut, expValid, expLen, expOk);
    end
  endtask

  // one clock: check the outputs from the previous cycle, then drive new inputs
  task automatic step(bit v, bit s, logic [WIDTH-1:0] a, logic [WIDTH-1:0] b,
                      int win, string tag);
    @(negedge clk);
    compareNow();
    validIn = v; subIn = s; opA = a; opB = b; window = LEN_W'(win);
    expValid = v;
    expTag = tag;
    if (v) begin
      expLen = refLen(a, b, s);
      expOk  = (expLen < win);
    end
  endtask

  task automatic idle(string tag);
    step(0, $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 33), tag);
  endtask

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    nVec++;
    if (validOut !== 1'b0 || lenOut !== '0 || okOut !== 1'b0) begin
      nBad++;
      $display("FAIL R9: got valid=%0b len=%0d ok=%0b, expected 0 0 0", validOut, lenOut, okOut);
    end
    rstN = 1'b1;
    expTag = "R9";
    idle("R9");

    // R4: no generate, addition
    step(1, 0, 32'h0000_0000, 32'h0000_0000, 1, "R4");
    step(1, 0, 32'hAAAA_AAAA, 32'h5555_5555, 1, "R4");
    // R2 / R1: single generate, then generate plus propagates
    step(1, 0, 32'h0000_0001, 32'h0000_0001, 8, "R2");
    step(1, 0, 32'h0000_0001, 32'h0000_000F, 8, "R2");
    // R3: annihilate stops, new generate restarts, top of word ends
    step(1, 0, 32'h0000_000F, 32'h0000_0001, 8, "R3");
    step(1, 0, 32'h0000_0007, 32'h0000_0005, 8, "R3");
    step(1, 0, 32'h0000_0003, 32'h0000_0003, 8, "R3");
    step(1, 0, 32'hFFFF_FFFF, 32'h0000_0001, 8, "R3");
    step(1, 0, 32'h8000_0000, 32'h8000_0000, 8, "R3");
    // R5: subtraction carry-in source
    step(1, 1, 32'h0000_0000, 32'h0000_0000, 8, "R5");
    step(1, 1, 32'h0000_0005, 32'h0000_0001, 8, "R5");
    step(1, 1, 32'h0000_0001, 32'h0000_0001, 8, "R5");
    step(1, 1, 32'hFFFF_FFFF, 32'h0000_0000, 8, "R5");
    // R6: window boundary, len 4 against window 4 and 5
    step(1, 0, 32'h0000_0001, 32'h0000_000F, 4, "R6");
    step(1, 0, 32'h0000_0001, 32'h0000_000F, 5, "R6");
    step(1, 0, 32'h0000_0000, 32'h0000_0000, 0, "R6");
    step(1, 1, 32'h0000_0000, 32'h0000_0000, 32, "R6");
    step(1, 1, 32'h0000_0000, 32'h0000_0000, 33, "R6");
    // R8: idle cycles keep the last result (valid drops, R7)
    step(1, 0, 32'h0000_0001, 32'h0000_0003, 3, "R8");
    for (int k = 0; k < 6; k++) idle("R8");
    // R7: alternating valid strobes
    for (int k = 0; k < 40; k++) begin
      if (k % 3 == 0) idle("R7");
      else step(1, $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 33), "R7");
    end
    // R5: small subtrahends
    for (int k = 0; k < 60; k++)
      step(1, 1, $urandom, WIDTH'($urandom_range(0, 15)), $urandom_range(0, 33), "R5");
    // R10 / R1: all-ones and mixed random operands
    step(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, "R10");
    step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, "R10");
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 4) == 0) idle("R8");
      else step(1, $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 33), "R1");
    end
    idle("R7");
    idle("R8");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule